// File: doc/BRIEF.md
# Fly-by DMA Strobe Sequencer

This block times one fly-by DMA transfer on the external bus. In a fly-by transfer an I/O device and a memory exchange data directly over the shared data pins. One side sources the data and the other side captures it, so the sequencer asserts a read strobe on one device and a write strobe on the other at the same time. A start request carries the direction and four timing settings. These are the I/O wait count, the memory wait count, a trailing idle count and a hold-extension enable. The sequencer then runs one access followed by zero to three bus-released idle cycles.

An access lasts one base cycle, plus the effective wait, plus one optional hold cycle. The effective wait is the larger of the two wait settings, so the slower device sets the pace. With hold extension on, the source read strobe stays active one cycle after the write strobe ends, which keeps the data valid while the destination captures it. Chip select and the data-bus drive enable cover the whole access. All outputs come from registers. A one-cycle done flag marks the final cycle of the sequence. During that done cycle a new request is accepted, so a channel can chain accesses without a gap.

Top module: `flyby_strobe_seq`

## Requirements
- R1: With dir_i = 0 (memory to I/O), an access asserts mem_rd_n_o and io_wr_n_o, and io_rd_n_o and mem_wr_n_o stay high. With dir_i = 1 (I/O to memory), it asserts io_rd_n_o and mem_wr_n_o, and mem_rd_n_o and io_wr_n_o stay high. All strobes and cs_n_o are active low.
- R2: The wait fields are plain 4-bit binary counts from 0 to 15. The effective wait W is the larger of io_wait_i and mem_wait_i. The write strobe stays low for exactly 1 + W cycles.
- R3: With hold_en_i = 0, the read strobe and the write strobe go low in the same cycle and return high in the same cycle. The access lasts 1 + W cycles.
- R4: With hold_en_i = 1, the read strobe stays low for exactly one cycle after the write strobe returns high. In that cycle cs_n_o stays low and data_oe_o stays high, so the access lasts 2 + W cycles.
- R5: idle_i is a 2-bit binary count from 0 to 3. That many cycles follow each access. During them cs_n_o and every strobe are high, data_oe_o is low and busy_o stays high.
- R6: With idle_i = 0, a request presented during the done cycle starts the next access in the very next cycle.
- R7: Outputs change on the first clock edge after a request is accepted. Under reset, cs_n_o and all strobes are high, and data_oe_o, busy_o and done_o are low.
- R8: A start_i pulse while busy_o is high, other than in the done cycle, is ignored. The running sequence keeps its timing and no extra access follows.
- R9: The direction and timing inputs are captured when a request is accepted. Changing them later has no effect on that sequence.
- R10: done_o is high for exactly the last cycle of the sequence. That is the last idle cycle, or the last access cycle when idle_i = 0. With no new request, busy_o is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Transfer request, taken when idle or in the done cycle |
| dir_i | input | 1 | 0 = memory to I/O, 1 = I/O to memory |
| io_wait_i | input | WAIT_W | I/O wait cycles |
| mem_wait_i | input | WAIT_W | Memory wait cycles |
| idle_i | input | IDLE_W | Idle cycles after the access |
| hold_en_i | input | 1 | Extend the read strobe by one cycle |
| cs_n_o | output | 1 | Chip select, active low |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |
| data_oe_o | output | 1 | Data pins in use; low means high impedance |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last cycle of the sequence |

## Verification
The bench builds the block with its default widths: 4-bit wait fields and a 2-bit idle field. Every wait value up to 15 is therefore reachable, including the longest access of 17 cycles with both waits at 15 and hold on. All four idle counts are also reachable. In these cases the bench can compare every cycle of the strobe pattern against a queue of predicted cycles, including chained accesses and ignored requests.

// File: rtl/flyby_seq_pkg.sv
// Shared types for the fly-by strobe sequencer.
// Assumes: nothing beyond the importing module's clocking.
package flyby_seq_pkg;

    // Sequence phase: waiting for a request, driving an access, bus-released gap
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACC  = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

    // Transfer direction encoding as seen on dir_i
    typedef enum logic {
        DIR_MEM2IO = 1'b0,
        DIR_IO2MEM = 1'b1
    } dir_e;

endpackage

// File: rtl/flyby_cfg_hold.sv
// Captures the transfer settings on acceptance and derives the cycle lengths.
// Provides both the held (current) values and the next values (new settings
// while loading, held ones otherwise).
// Assumes: load_i is high only on the cycle a request is accepted.
module flyby_cfg_hold #(
    parameter int WAIT_W = 4,
    parameter int IDLE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              dir_i,
    input  logic [WAIT_W-1:0] io_wait_i,
    input  logic [WAIT_W-1:0] mem_wait_i,
    input  logic [IDLE_W-1:0] idle_i,
    input  logic              hold_i,
    output logic              dir_d_o,
    output logic [WAIT_W:0]   wr_len_d_o,
    output logic [WAIT_W:0]   acc_len_d_o,
    output logic [WAIT_W:0]   idle_len_d_o,
    output logic              dir_q_o,
    output logic [WAIT_W:0]   wr_len_q_o,
    output logic [WAIT_W:0]   acc_len_q_o,
    output logic [WAIT_W:0]   idle_len_q_o
);

    localparam int CNT_W = WAIT_W + 1;

    logic [WAIT_W-1:0] wait_eff;
    logic [CNT_W-1:0]  new_wr, new_acc, new_idle;

    // Derive the lengths from the raw request settings
    always_comb begin
        wait_eff = (io_wait_i > mem_wait_i) ? io_wait_i : mem_wait_i;
        new_wr   = {1'b0, wait_eff} + CNT_W'(1);
        new_acc  = new_wr + CNT_W'(hold_i);
        new_idle = CNT_W'(idle_i);
    end

    // Select the settings in force for the next cycle
    always_comb begin
        dir_d_o      = load_i ? dir_i    : dir_q_o;
        wr_len_d_o   = load_i ? new_wr   : wr_len_q_o;
        acc_len_d_o  = load_i ? new_acc  : acc_len_q_o;
        idle_len_d_o = load_i ? new_idle : idle_len_q_o;
    end

    // Hold the settings of the sequence in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q_o      <= 1'b0;
            wr_len_q_o   <= CNT_W'(1);
            acc_len_q_o  <= CNT_W'(1);
            idle_len_q_o <= '0;
        end else begin
            dir_q_o      <= dir_d_o;
            wr_len_q_o   <= wr_len_d_o;
            acc_len_q_o  <= acc_len_d_o;
            idle_len_q_o <= idle_len_d_o;
        end
    end

endmodule

// File: rtl/flyby_phase_ctrl.sv
// Phase and cycle counter of the sequencer. Accepts a request when idle or
// in the final cycle of a sequence, then steps through access and gap.
// Assumes: lengths come from flyby_cfg_hold; acc_len_q_i is at least 1.
module flyby_phase_ctrl
    import flyby_seq_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [WAIT_W:0] acc_len_q_i,
    input  logic [WAIT_W:0] idle_len_q_i,
    output logic          accept_o,
    output phase_e        phase_d_o,
    output logic [WAIT_W:0] cnt_d_o
);

    localparam int CNT_W = WAIT_W + 1;

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             acc_end, gap_end, seq_last;

    // Detect the end of each phase and of the whole sequence
    always_comb begin
        acc_end  = (phase_q == PH_ACC) && (cnt_q == acc_len_q_i - CNT_W'(1));
        gap_end  = (phase_q == PH_GAP) && (cnt_q == idle_len_q_i - CNT_W'(1));
        seq_last = (acc_end && (idle_len_q_i == '0)) || gap_end;
        accept_o = start_i && ((phase_q == PH_IDLE) || seq_last);
    end

    // Next phase and counter
    always_comb begin
        phase_d_o = phase_q;
        cnt_d_o   = cnt_q + CNT_W'(1);
        if (accept_o) begin
            phase_d_o = PH_ACC;
            cnt_d_o   = '0;
        end else if (acc_end) begin
            phase_d_o = (idle_len_q_i == '0) ? PH_IDLE : PH_GAP;
            cnt_d_o   = '0;
        end else if (gap_end || (phase_q == PH_IDLE)) begin
            phase_d_o = PH_IDLE;
            cnt_d_o   = '0;
        end
    end

    // Phase and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d_o;
            cnt_q   <= cnt_d_o;
        end
    end

endmodule

// File: rtl/flyby_strobe_drv.sv
// Decodes the next phase into bus controls and registers them, so every
// pin changes only at a clock edge.
// Assumes: phase and count inputs are the values for the next cycle.
module flyby_strobe_drv
    import flyby_seq_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          phase_d_i,
    input  logic [WAIT_W:0] cnt_d_i,
    input  logic            dir_d_i,
    input  logic [WAIT_W:0] wr_len_d_i,
    input  logic [WAIT_W:0] acc_len_d_i,
    input  logic [WAIT_W:0] idle_len_d_i,
    output logic            cs_n_o,
    output logic            mem_rd_n_o,
    output logic            mem_wr_n_o,
    output logic            io_rd_n_o,
    output logic            io_wr_n_o,
    output logic            data_oe_o,
    output logic            busy_o,
    output logic            done_o
);

    localparam int CNT_W = WAIT_W + 1;

    logic in_acc, rd_on, wr_on, m2io, fin;

    // Decide which strobes are active in the next cycle
    always_comb begin
        in_acc = (phase_d_i == PH_ACC);
        rd_on  = in_acc;
        wr_on  = in_acc && (cnt_d_i < wr_len_d_i);
        m2io   = (dir_d_i == DIR_MEM2IO);
        fin    = (in_acc && (cnt_d_i == acc_len_d_i - CNT_W'(1)) && (idle_len_d_i == '0))
              || ((phase_d_i == PH_GAP) && (cnt_d_i == idle_len_d_i - CNT_W'(1)));
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o     <= 1'b1;
            mem_rd_n_o <= 1'b1;
            mem_wr_n_o <= 1'b1;
            io_rd_n_o  <= 1'b1;
            io_wr_n_o  <= 1'b1;
            data_oe_o  <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            cs_n_o     <= !in_acc;
            mem_rd_n_o <= !(rd_on && m2io);
            io_wr_n_o  <= !(wr_on && m2io);
            io_rd_n_o  <= !(rd_on && !m2io);
            mem_wr_n_o <= !(wr_on && !m2io);
            data_oe_o  <= in_acc;
            busy_o     <= (phase_d_i != PH_IDLE);
            done_o     <= fin;
        end
    end

endmodule

// File: rtl/flyby_strobe_seq.sv
// Top of the fly-by DMA strobe sequencer: settings capture, phase control
// and registered pin drive.
// Assumes: synchronous active-low reset; the caller holds start_i until
// it sees busy_o rise, or drops it after one cycle.
module flyby_strobe_seq
    import flyby_seq_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int IDLE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [WAIT_W-1:0] io_wait_i,
    input  logic [WAIT_W-1:0] mem_wait_i,
    input  logic [IDLE_W-1:0] idle_i,
    input  logic              hold_en_i,
    output logic              cs_n_o,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o,
    output logic              io_rd_n_o,
    output logic              io_wr_n_o,
    output logic              data_oe_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = WAIT_W + 1;

    logic             accept;
    phase_e           phase_d;
    logic [CNT_W-1:0] cnt_d;
    logic             dir_d, dir_q;
    logic [CNT_W-1:0] wr_len_d, acc_len_d, idle_len_d;
    logic [CNT_W-1:0] wr_len_q, acc_len_q, idle_len_q;

    flyby_cfg_hold #(.WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .dir_i        (dir_i),
        .io_wait_i    (io_wait_i),
        .mem_wait_i   (mem_wait_i),
        .idle_i       (idle_i),
        .hold_i       (hold_en_i),
        .dir_d_o      (dir_d),
        .wr_len_d_o   (wr_len_d),
        .acc_len_d_o  (acc_len_d),
        .idle_len_d_o (idle_len_d),
        .dir_q_o      (dir_q),
        .wr_len_q_o   (wr_len_q),
        .acc_len_q_o  (acc_len_q),
        .idle_len_q_o (idle_len_q)
    );

    flyby_phase_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .acc_len_q_i  (acc_len_q),
        .idle_len_q_i (idle_len_q),
        .accept_o     (accept),
        .phase_d_o    (phase_d),
        .cnt_d_o      (cnt_d)
    );

    flyby_strobe_drv #(.WAIT_W(WAIT_W)) u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_d_i    (phase_d),
        .cnt_d_i      (cnt_d),
        .dir_d_i      (dir_d),
        .wr_len_d_i   (wr_len_d),
        .acc_len_d_i  (acc_len_d),
        .idle_len_d_i (idle_len_d),
        .cs_n_o       (cs_n_o),
        .mem_rd_n_o   (mem_rd_n_o),
        .mem_wr_n_o   (mem_wr_n_o),
        .io_rd_n_o    (io_rd_n_o),
        .io_wr_n_o    (io_wr_n_o),
        .data_oe_o    (data_oe_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    // Held direction and write length are kept for the settings path only
    logic unused_q;
    assign unused_q = ^{dir_q, wr_len_q};

endmodule

// File: rtl/flyby_seq_chk.sv
// Protocol checker for the fly-by strobe sequencer, attached by bind.
// Assumes: it observes the top-level pins only.
module flyby_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic mem_rd_n_o,
    input logic mem_wr_n_o,
    input logic io_rd_n_o,
    input logic io_wr_n_o,
    input logic data_oe_o,
    input logic busy_o,
    input logic done_o
);

    // R1
    one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_n_o || mem_wr_n_o) && (io_rd_n_o || io_wr_n_o));

    // R4
    wr_in_rd_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n_o |-> !io_rd_n_o);

    // R4
    wr_in_rd_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr_n_o |-> !mem_rd_n_o);

    // R5
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cs_n_o) |-> (mem_rd_n_o && mem_wr_n_o && io_rd_n_o && io_wr_n_o && !data_oe_o));

    // R7
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n_o || !mem_wr_n_o || !io_rd_n_o || !io_wr_n_o) |-> !cs_n_o);

    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !data_oe_o && !done_o));

endmodule

bind flyby_strobe_seq flyby_seq_chk u_chk (.*);

// File: tb/sim_flyby_strobe_seq.sv
// Scoreboard bench: the driver queues the expected pin pattern of each
// cycle, and the monitor pops and compares one entry per clock.
module sim_flyby_strobe_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       dir_i = 1'b0;
    logic [3:0] io_wait_i = '0;
    logic [3:0] mem_wait_i = '0;
    logic [1:0] idle_i = '0;
    logic       hold_en_i = 1'b0;
    logic cs_n_o, mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o;
    logic data_oe_o, busy_o, done_o;

    flyby_strobe_seq u0 (.*);

    always #10 clk = ~clk;   // 50 MHz

    // {cs_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, data_oe, busy, done}
    localparam logic [7:0] IDLE_V = 8'b1111_1000;
    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    int n_run = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    logic [7:0] obs;
    assign obs = {cs_n_o, mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o, data_oe_o, busy_o, done_o};

    // Monitor: compare one expected cycle per falling edge
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e.v = IDLE_V; e.tag = "R10"; end
            n_run++;
            if (obs !== e.v) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b at %0t", e.tag, obs, e.v, $time);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Queue the predicted cycles of one sequence (R2 R3 R4 R5 R10)
    task automatic push_exp(bit dir, int iow, int mw, bit hold, int idl, string tag, output int n);
        int w = (iow > mw) ? iow : mw;
        int len = 1 + w + int'(hold);
        for (int c = 1; c <= len; c++) begin
            exp_t e;
            bit wr = (c <= 1 + w);
            e.v[7] = 1'b0;
            e.v[6] = !(dir == 1'b0);
            e.v[5] = !(dir == 1'b1 && wr);
            e.v[4] = !(dir == 1'b1);
            e.v[3] = !(dir == 1'b0 && wr);
            e.v[2] = 1'b1;
            e.v[1] = 1'b1;
            e.v[0] = (c == len) && (idl == 0);
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int c = 1; c <= idl; c++) begin
            exp_t e;
            e.v = {5'b11111, 1'b0, 1'b1, (c == idl)};
            e.tag = tag;
            exp_q.push_back(e);
        end
        n = len + idl;
    endtask

    // Driver: issue one request, then scramble settings (R9); optional
    // start pulse while busy (R8). Returns on the done cycle.
    task automatic xfer(bit dir, int iow, int mw, bit hold, int idl, string tag, bit poke);
        int n;
        dir_i = dir; io_wait_i = 4'(iow); mem_wait_i = 4'(mw);
        hold_en_i = hold; idle_i = 2'(idl); start_i = 1'b1;
        push_exp(dir, iow, mw, hold, idl, tag, n);
        step();
        start_i = poke;
        dir_i = ~dir; io_wait_i = ~4'(iow); mem_wait_i = ~4'(mw);
        hold_en_i = ~hold; idle_i = ~2'(idl);
        if (poke) begin
            step();
            start_i = 1'b0;
            n = n - 1;
        end
        repeat (n - 1) step();
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL R10: watchdog expired, actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R7 reset state
        n_run++;
        if (obs !== IDLE_V) begin
            n_fail++;
            $display("FAIL R7: actual %b expected %b", obs, IDLE_V);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) step();

        xfer(1'b0, 0, 0, 1'b0, 0, "R1", 1'b0);     // shortest, memory to I/O
        repeat (2) step();
        xfer(1'b1, 0, 0, 1'b0, 0, "R1", 1'b0);     // shortest, I/O to memory
        repeat (2) step();
        xfer(1'b1, 3, 7, 1'b0, 2, "R2", 1'b0);     // memory wait dominates
        repeat (1) step();
        xfer(1'b0, 9, 2, 1'b0, 1, "R3", 1'b0);     // I/O wait dominates
        repeat (3) step();
        xfer(1'b0, 4, 4, 1'b1, 3, "R4", 1'b0);     // hold cycle
        repeat (1) step();
        xfer(1'b1, 0, 0, 1'b1, 1, "R4", 1'b0);     // hold with no wait
        repeat (2) step();
        xfer(1'b1, 15, 15, 1'b1, 3, "R2", 1'b0);   // longest access
        repeat (2) step();
        xfer(1'b0, 2, 0, 1'b0, 3, "R5", 1'b0);     // full idle gap
        repeat (2) step();
        xfer(1'b0, 1, 0, 1'b0, 0, "R6", 1'b0);     // chained accesses
        xfer(1'b1, 0, 2, 1'b1, 0, "R6", 1'b0);
        xfer(1'b0, 0, 0, 1'b0, 0, "R6", 1'b0);
        repeat (2) step();
        xfer(1'b1, 5, 0, 1'b0, 2, "R8", 1'b1);     // request while busy
        repeat (2) step();
        xfer(1'b0, 6, 1, 1'b1, 0, "R9", 1'b0);     // settings changed mid-access
        xfer(1'b1, 2, 3, 1'b0, 1, "R10", 1'b0);
        repeat (4) step();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule